// File: doc/BRIEF.md
# Signed Multiply-Accumulate Coprocessor with Mode Register

This block sits beside a 16-bit CPU and carries out signed multiply-accumulate work on a 32-bit accumulator. The CPU first writes an 8-bit mode code. It then issues operand commands, each carrying two 16-bit arguments. Depending on the mode, a command does one of three things:

- it preloads the accumulator;
- it multiplies the two arguments and adds the product to the accumulator;
- it leaves the accumulator alone.

Each operand command returns two registered values one cycle later: a 16-bit word taken from one half of the accumulator, and a 4-bit flag vector ordered carry, overflow, zero, negative. The accumulator keeps its value across commands and across mode changes. Because of this, the CPU can run a product sum, switch to the high-half view, and read the upper word back.

The second argument may come from a register or from a sign-extended immediate. The coprocessor cannot tell these apart, because both arrive as a plain 16-bit word.

Top module: `mac_copro`

## Requirements
- R1: After reset the mode register holds 0x00, the accumulator holds 0, and `res_out` and `flags_out` are both 0.
- R2: Writing mode code 0x00 clears the whole 32-bit accumulator on that edge, with no operand command needed.
- R3: In mode 0x01, an operand command sets the accumulator to {16'h0, `arg_b`}. Its `res_out` is `arg_b` and its flags are 0000.
- R4: In mode 0x02, an operand command sets the accumulator to {`arg_a`, `arg_b`}. Its `res_out` is `arg_b` and its flags are 0000.
- R5: In mode 0x07, an operand command sets the accumulator to `arg_a` × `arg_b` + accumulator, using signed 16-bit operands and a sum that wraps modulo 2^32. The command returns the new accumulator's bits [15:0] on `res_out` in the cycle after `op_valid`.
- R6: Mode 0x17 accumulates in the same way as 0x07, but `res_out` returns bits [31:16] of the new accumulator.
- R7: After a multiply-accumulate, `flags_out` (bit 3 C, bit 2 V, bit 1 Z, bit 0 N) is 4'b0100 when the product and the old accumulator share a sign and the new accumulator has the other sign. Otherwise it is 4'b0000.
- R8: Only the mode 0x00 write and operand commands in modes 0x01, 0x02, 0x07 and 0x17 change the accumulator. A value survives any other mode write and can be read back later through mode 0x17.
- R9: In any other mode (for example 0x13), an operand command leaves the accumulator unchanged, returns accumulator bits [15:0] and returns flags 0000.
- R10: `res_out` and `flags_out` change only in the cycle after an accepted operand command, and otherwise hold their value.
- R11: When `mode_wr` and `op_valid` are high in the same cycle, the mode write takes effect and the operand command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode code write strobe |
| mode_code | input | 8 | Mode code to write |
| op_valid | input | 1 | Operand command strobe |
| arg_a | input | 16 | First operand |
| arg_b | input | 16 | Second operand (register value or sign-extended immediate) |
| res_out | output | 16 | Selected half of the accumulator, registered |
| flags_out | output | 4 | C, V, Z, N flags, registered |

## Verification
Every mode is driven with all pairs drawn from a set of edge operands: zero, ±1, ±2, the most positive and most negative 16-bit values, and mixed bit patterns. This sweep separates signed from unsigned multiplication and the low half from the high half, and it triggers overflow in both directions. Preloads with extreme accumulator values are followed by unit products, which places overflow right at the wrap point. Zero-product reads in mode 0x17 expose the upper accumulator half after loads, after mode changes and after dropped commands, which shows which operations touched the accumulator. A mode write issued in the same cycle as an operand command checks that the command is discarded.

// File: rtl/mac_copro.sv
module mac_copro #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_wr,
  input  logic [7:0]   mode_code,
  input  logic         op_valid,
  input  logic [W-1:0] arg_a,
  input  logic [W-1:0] arg_b,
  output logic [W-1:0] res_out,
  output logic [3:0]   flags_out
);
  localparam int AW = 2 * W;
  localparam logic [7:0] M_CLR  = 8'h00;
  localparam logic [7:0] M_LDLO = 8'h01;
  localparam logic [7:0] M_LDHL = 8'h02;
  localparam logic [7:0] M_MACL = 8'h07;
  localparam logic [7:0] M_MACH = 8'h17;
  localparam logic [3:0] F_OVF  = 4'b0100;

  logic [7:0]           mode_q;
  logic [AW-1:0]        acc_q, acc_nx;
  logic signed [AW-1:0] prod;
  logic [AW-1:0]        sum;
  logic                 is_mac, ovf, take_op;

  assign take_op = op_valid && !mode_wr;
  assign is_mac  = (mode_q == M_MACL) || (mode_q == M_MACH);
  assign prod    = $signed(arg_a) * $signed(arg_b);
  assign sum     = acc_q + prod;
  assign ovf     = (prod[AW-1] == acc_q[AW-1]) && (sum[AW-1] != prod[AW-1]);

  always_comb begin
    case (mode_q)
      M_LDLO:         acc_nx = {{W{1'b0}}, arg_b};
      M_LDHL:         acc_nx = {arg_a, arg_b};
      M_MACL, M_MACH: acc_nx = sum;
      default:        acc_nx = acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= M_CLR;
      acc_q     <= '0;
      res_out   <= '0;
      flags_out <= '0;
    end else if (mode_wr) begin
      mode_q <= mode_code;
      if (mode_code == M_CLR) acc_q <= '0;
    end else if (op_valid) begin
      acc_q     <= acc_nx;
      res_out   <= (mode_q == M_MACH) ? acc_nx[AW-1:W] : acc_nx[W-1:0];
      flags_out <= (is_mac && ovf) ? F_OVF : 4'b0000;
    end
  end

  // R2
  clear_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && mode_code == M_CLR |=> acc_q == '0);
  // R5
  low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_op && mode_q == M_MACL |=> res_out == acc_q[W-1:0]);
  // R6
  high_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_op && mode_q == M_MACH |=> res_out == acc_q[AW-1:W]);
  // R7
  flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_out == 4'b0000 || flags_out == F_OVF);
  // R9
  unlisted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_op && !is_mac && mode_q != M_LDLO && mode_q != M_LDHL
    |=> $stable(acc_q) && flags_out == 4'b0000);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_op |=> $stable(res_out) && $stable(flags_out));
  // R11
  drop_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && mode_code != M_CLR |=> $stable(acc_q));
endmodule

// File: tb/mac_copro_tb.sv
module mac_copro_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [7:0]  mode_code = 8'h00;
  logic        op_valid = 1'b0;
  logic [15:0] arg_a = '0;
  logic [15:0] arg_b = '0;
  logic [15:0] res_out;
  logic [3:0]  flags_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_acc = '0;
  logic [7:0]  m_mode = 8'h00;
  logic [15:0] vals [12];

  mac_copro u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [15:0] r, logic [15:0] er, logic [3:0] f, logic [3:0] ef);
    n_chk++;
    if (r !== er || f !== ef) begin
      n_bad++;
      $display("FAIL %s: res=%h flags=%b, expected res=%h flags=%b", req, r, f, er, ef);
    end
  endtask

  task automatic set_mode(logic [7:0] c);
    @(negedge clk);
    mode_wr = 1'b1; mode_code = c;
    @(negedge clk);
    mode_wr = 1'b0;
    m_mode = c;
    if (c == 8'h00) m_acc = '0;
  endtask

  task automatic do_op(logic [15:0] a, logic [15:0] b, string req);
    logic signed [31:0] p;
    logic [31:0] s;
    logic [15:0] er;
    logic [3:0]  ef;
    @(negedge clk);
    op_valid = 1'b1; arg_a = a; arg_b = b;
    @(negedge clk);
    op_valid = 1'b0;
    p = $signed(a) * $signed(b);
    s = m_acc + p;
    ef = 4'b0000;
    case (m_mode)
      8'h01: m_acc = {16'h0, b};
      8'h02: m_acc = {a, b};
      8'h07, 8'h17: begin
        if (p[31] == m_acc[31] && s[31] != p[31]) ef = 4'b0100;
        m_acc = s;
      end
      default: ;
    endcase
    er = (m_mode == 8'h17) ? m_acc[31:16] : m_acc[15:0];
    check(req, res_out, er, flags_out, ef);
  endtask

  task automatic read_high(string req);
    logic [7:0] keep;
    keep = m_mode;
    set_mode(8'h17);
    do_op(16'h0000, 16'h0000, req);
    if (keep != 8'h17) set_mode(keep);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    vals = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0002, 16'hFFFE, 16'h7FFF,
             16'h8000, 16'h1234, 16'hEDCB, 16'h00FF, 16'h8001, 16'h4000};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", res_out, 16'h0000, flags_out, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", res_out, 16'h0000, flags_out, 4'b0000);
    read_high("R1");

    // R3 low preload sweep
    set_mode(8'h01);
    foreach (vals[i]) foreach (vals[j]) do_op(vals[i], vals[j], "R3");
    read_high("R3");

    // R4 full preload sweep, high half read back (R8)
    set_mode(8'h02);
    foreach (vals[i]) foreach (vals[j]) do_op(vals[i], vals[j], "R4");
    do_op(16'hA5C3, 16'h1111, "R4");
    set_mode(8'h13);
    set_mode(8'h07);
    read_high("R8");

    // R2 clear on mode write alone
    set_mode(8'h02);
    do_op(16'hDEAD, 16'hBEEF, "R4");
    set_mode(8'h00);
    read_high("R2");
    set_mode(8'h07);
    do_op(16'h0000, 16'h0000, "R2");

    // R5 and R7 MAC low sweep
    set_mode(8'h07);
    foreach (vals[i]) foreach (vals[j]) do_op(vals[i], vals[j], "R5");

    // R6 and R7 MAC high sweep
    set_mode(8'h17);
    foreach (vals[i]) foreach (vals[j]) do_op(vals[i], vals[j], "R6");

    // R7 overflow at the positive wrap point
    set_mode(8'h02);
    do_op(16'h7FFF, 16'hFFFF, "R4");
    set_mode(8'h17);
    do_op(16'h0001, 16'h0001, "R7");
    do_op(16'h0001, 16'h0001, "R7");
    // R7 overflow at the negative wrap point
    set_mode(8'h02);
    do_op(16'h8000, 16'h0000, "R4");
    set_mode(8'h07);
    do_op(16'hFFFF, 16'h0001, "R7");
    read_high("R7");

    // R9 unlisted mode leaves accumulator, zero flags
    set_mode(8'h02);
    do_op(16'h5A5A, 16'h3C3C, "R4");
    set_mode(8'h13);
    foreach (vals[i]) do_op(vals[i], vals[11 - i], "R9");
    read_high("R9");

    // R10 outputs hold without a command
    set_mode(8'h07);
    do_op(16'h0003, 16'h0005, "R5");
    repeat (4) @(negedge clk);
    check("R10", res_out, m_acc[15:0], flags_out, 4'b0000);
    set_mode(8'h13);
    check("R10", res_out, m_acc[15:0], flags_out, 4'b0000);
    set_mode(8'h07);

    // R11 mode write wins over a same-cycle command
    @(negedge clk);
    mode_wr = 1'b1; mode_code = 8'h01;
    op_valid = 1'b1; arg_a = 16'h7FFF; arg_b = 16'h7FFF;
    @(negedge clk);
    mode_wr = 1'b0; op_valid = 1'b0;
    m_mode = 8'h01;
    check("R11", res_out, m_acc[15:0], flags_out, 4'b0000);
    read_high("R11");
    set_mode(8'h01);
    do_op(16'h0000, 16'h2222, "R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule